// File: doc/BRIEF.md
# Radix-2 Butterfly Stage with Transform Checksum Guard

This block is one radix-2 butterfly of a fixed-point FFT engine with a low-cost result checker attached. It takes a stream of complex input pairs, each with its own twiddle factor. For every pair it produces the sum and the difference of the first operand and the twiddled second operand. An outer sequencer, which is not part of this block, feeds the pairs of one transform pass. It opens each pass with a start pulse that also carries the first time-domain sample of the transform.

While the pass runs, the checker adds up every output point. When the last pair has left, it scales the totals down by the point count and compares them with the captured first sample. A deviation larger than the rounding allowance flags an error. It also raises a replay request, which stays up until the sequencer starts the transform again.

A build-time parameter picks one of two datapath variants:
- The full-rate variant accepts one pair every cycle and registers its result one cycle later.
- The half-rate variant time-shares two real multipliers over two cycles. It therefore takes one pair every other cycle, with two cycles of latency.

Top module: `fft_bfly_guard`

## Requirements
- R1: For operands a, b and twiddle w, with each 32-bit pair word holding the real part in bits 31:16 and the imaginary part in bits 15:0 (signed Q15), the block computes p = round(b*w). The complex product uses full-precision intermediates. Each part is rounded as (s + 2^14) arithmetically shifted right by 15. The outputs are x = a + p and y = a - p, each wrapped to 16 bits.
- R2: With HALF_RATE = 0, in_ready stays high while pairs are still owed. The result of a pair accepted at a clock edge appears with out_valid in the cycle that follows that edge.
- R3: With HALF_RATE = 1, the result appears two cycles after the accepting edge. in_ready is low in the cycle right after an acceptance.
- R4: A pair is accepted only after start and only until N/2 pairs (N = 2^LOG2N) have been taken in the current pass. At all other times in_valid is ignored: no pair is taken and no output appears.
- R5: done is a single-cycle pulse in the cycle after the one carrying the last output pair of the pass.
- R6: The check adds the real parts, and separately the imaginary parts, of all N output points. Each total is arithmetically shifted right by LOG2N and compared with the matching part of first_pt as sampled at start. The pass succeeds only if both differences are within ±N.
- R7: error is high only together with done, and only when the R6 check fails.
- R8: replay rises with a failing done. It then holds high until start, and it is low in the cycle after start.
- R9: After reset, out_valid, done, error, replay and in_ready are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a pass; samples first_pt and clears the checker |
| first_pt | input | 32 | First time-domain sample {re, im} |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Block will take the pair at this edge |
| a_pt | input | 32 | Upper butterfly operand {re, im} |
| b_pt | input | 32 | Lower butterfly operand {re, im} |
| tw_pt | input | 32 | Twiddle factor {re, im}, Q15 |
| out_valid | output | 1 | Output pair present |
| x_pt | output | 32 | a + b*w {re, im} |
| y_pt | output | 32 | a - b*w {re, im} |
| done | output | 1 | Pass complete pulse |
| error | output | 1 | Checksum mismatch, with done |
| replay | output | 1 | Replay request, held until start |

## Verification
An upset in the multiplier path or its phase register shows up as a wrong x or y in the very output cycle of that pair. However, the x + y totals cancel the product, so the checksum does not catch it; only the scoreboard comparison of each pair does. A corrupted accumulator, a wrong sampled first point or an off-by-one pair count is visible only at the end of the pass. It then appears as a misplaced done, a spurious or missing error, or a replay that does not hold until the next start. The bench therefore drives passes that sit exactly on both sides of the ±N allowance, in the real and in the imaginary part.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    localparam int CW = 16;

    typedef logic signed [CW-1:0] smp_t;

    // real part occupies the upper half of the packed word
    typedef struct packed {
        smp_t re;
        smp_t im;
    } cpx_t;

    typedef logic signed [2*CW:0] wide_t;

    typedef enum logic {
        PH_OPEN   = 1'b0,
        PH_FINISH = 1'b1
    } ph_e;

    function automatic wide_t mulw(input smp_t p, input smp_t q);
        wide_t wp;
        wide_t wq;
        wp = wide_t'(p);
        wq = wide_t'(q);
        return wp * wq;
    endfunction

    // round half up, then drop the Q15 fraction
    function automatic smp_t rnd_q(input wide_t s);
        wide_t t;
        t = s + wide_t'(1 <<< (CW - 2));
        t = t >>> (CW - 1);
        return t[CW-1:0];
    endfunction

    function automatic cpx_t bf_add(input cpx_t a, input smp_t pr, input smp_t pi);
        cpx_t r;
        r.re = a.re + pr;
        r.im = a.im + pi;
        return r;
    endfunction

    function automatic cpx_t bf_sub(input cpx_t a, input smp_t pr, input smp_t pi);
        cpx_t r;
        r.re = a.re - pr;
        r.im = a.im - pi;
        return r;
    endfunction

endpackage

// File: rtl/bfly_dp.sv
module bfly_dp
    import bfly_pkg::*;
#(
    parameter bit HALF = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  cpx_t a,
    input  cpx_t b,
    input  cpx_t w,
    output logic rdy,
    output logic ov,
    output cpx_t x,
    output cpx_t y
);

    generate
        if (!HALF) begin : g_full
            smp_t pr;
            smp_t pi;

            always_comb begin
                pr = rnd_q(mulw(b.re, w.re) - mulw(b.im, w.im));
                pi = rnd_q(mulw(b.re, w.im) + mulw(b.im, w.re));
            end

            assign rdy = 1'b1;

            always_ff @(posedge clk) begin
                if (rst) begin
                    ov <= 1'b0;
                    x  <= '0;
                    y  <= '0;
                end else begin
                    ov <= take;
                    if (take) begin
                        x <= bf_add(a, pr, pi);
                        y <= bf_sub(a, pr, pi);
                    end
                end
            end

            a_r2_next_cycle: assert property (@(posedge clk) disable iff (rst)
                take |=> ov);

        end else begin : g_half
            ph_e   ph;
            cpx_t  sa;
            cpx_t  sb;
            cpx_t  sw;
            wide_t re_s;
            wide_t m0;
            wide_t m1;
            logic  fin;

            assign fin = (ph == PH_FINISH);

            // two shared multipliers: real-part terms from the live inputs,
            // imaginary-part terms from the held operands one cycle later
            always_comb begin
                m0 = mulw(fin ? sb.re : b.re, fin ? sw.im : w.re);
                m1 = mulw(fin ? sb.im : b.im, fin ? sw.re : w.im);
            end

            assign rdy = !fin;

            always_ff @(posedge clk) begin
                if (rst) begin
                    ph   <= PH_OPEN;
                    ov   <= 1'b0;
                    sa   <= '0;
                    sb   <= '0;
                    sw   <= '0;
                    re_s <= '0;
                    x    <= '0;
                    y    <= '0;
                end else begin
                    ov <= 1'b0;
                    if (fin) begin
                        ov <= 1'b1;
                        x  <= bf_add(sa, rnd_q(re_s), rnd_q(m0 + m1));
                        y  <= bf_sub(sa, rnd_q(re_s), rnd_q(m0 + m1));
                        ph <= PH_OPEN;
                    end else if (take) begin
                        sa   <= a;
                        sb   <= b;
                        sw   <= w;
                        re_s <= m0 - m1;
                        ph   <= PH_FINISH;
                    end
                end
            end

            a_r3_gap: assert property (@(posedge clk) disable iff (rst)
                take |=> !rdy);

            a_r3_two_cycles: assert property (@(posedge clk) disable iff (rst)
                take |=> ##1 ov);
        end
    endgenerate

endmodule

// File: rtl/bfly_chk.sv
module bfly_chk
    import bfly_pkg::*;
#(
    parameter int LOG2N = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  cpx_t refp,
    input  logic ov,
    input  logic last,
    input  cpx_t x,
    input  cpx_t y,
    output logic done,
    output logic error,
    output logic replay
);

    localparam int AW = CW + LOG2N + 1;
    localparam logic signed [AW-1:0] TOL = AW'(1 << LOG2N);

    typedef logic signed [AW-1:0] acc_t;

    function automatic acc_t ext(input smp_t v);
        return {{(AW-CW){v[CW-1]}}, v};
    endfunction

    acc_t acc_re;
    acc_t acc_im;
    acc_t nre;
    acc_t nim;
    acc_t dre;
    acc_t dim;
    cpx_t ref_q;
    logic bad;

    always_comb begin
        nre = acc_re + ext(x.re) + ext(y.re);
        nim = acc_im + ext(x.im) + ext(y.im);
        dre = (nre >>> LOG2N) - ext(ref_q.re);
        dim = (nim >>> LOG2N) - ext(ref_q.im);
        bad = (dre > TOL) || (dre < -TOL) || (dim > TOL) || (dim < -TOL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_re <= '0;
            acc_im <= '0;
            ref_q  <= '0;
            done   <= 1'b0;
            error  <= 1'b0;
            replay <= 1'b0;
        end else begin
            done  <= 1'b0;
            error <= 1'b0;
            if (ov) begin
                acc_re <= nre;
                acc_im <= nim;
            end
            if (last) begin
                done  <= 1'b1;
                error <= bad;
                if (bad) replay <= 1'b1;
            end
            if (clear) begin
                acc_re <= '0;
                acc_im <= '0;
                ref_q  <= refp;
                replay <= 1'b0;
            end
        end
    end

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_err_with_done: assert property (@(posedge clk) disable iff (rst)
        error |-> done);

    a_r8_replay_hold: assert property (@(posedge clk) disable iff (rst)
        (replay && !clear) |=> replay);

    a_r8_replay_clear: assert property (@(posedge clk) disable iff (rst)
        clear |=> !replay);

endmodule

// File: rtl/fft_bfly_guard.sv
module fft_bfly_guard
    import bfly_pkg::*;
#(
    parameter int LOG2N     = 3,
    parameter bit HALF_RATE = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] first_pt,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] a_pt,
    input  logic [31:0] b_pt,
    input  logic [31:0] tw_pt,
    output logic        out_valid,
    output logic [31:0] x_pt,
    output logic [31:0] y_pt,
    output logic        done,
    output logic        error,
    output logic        replay
);

    localparam int PAIRS = 1 << (LOG2N - 1);
    localparam logic [LOG2N-1:0] PAIRS_V = LOG2N'(PAIRS);
    localparam logic [LOG2N-1:0] LAST_V  = LOG2N'(PAIRS - 1);

    logic             run;
    logic [LOG2N-1:0] in_cnt;
    logic [LOG2N-1:0] out_cnt;
    logic             dp_rdy;
    logic             dp_ov;
    logic             take;
    logic             last;
    cpx_t             dx;
    cpx_t             dy;

    assign in_ready  = run && (in_cnt != PAIRS_V) && dp_rdy;
    assign take      = in_valid && in_ready;
    assign last      = dp_ov && (out_cnt == LAST_V);
    assign out_valid = dp_ov;
    assign x_pt      = dx;
    assign y_pt      = dy;

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 1'b0;
            in_cnt  <= '0;
            out_cnt <= '0;
        end else begin
            if (take)  in_cnt  <= in_cnt + 1'b1;
            if (dp_ov) out_cnt <= out_cnt + 1'b1;
            if (last)  run     <= 1'b0;
            if (start) begin
                run     <= 1'b1;
                in_cnt  <= '0;
                out_cnt <= '0;
            end
        end
    end

    bfly_dp #(.HALF(HALF_RATE)) u_dp (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .a    (cpx_t'(a_pt)),
        .b    (cpx_t'(b_pt)),
        .w    (cpx_t'(tw_pt)),
        .rdy  (dp_rdy),
        .ov   (dp_ov),
        .x    (dx),
        .y    (dy)
    );

    bfly_chk #(.LOG2N(LOG2N)) u_chk (
        .clk    (clk),
        .rst    (rst),
        .clear  (start),
        .refp   (cpx_t'(first_pt)),
        .ov     (dp_ov),
        .last   (last),
        .x      (dx),
        .y      (dy),
        .done   (done),
        .error  (error),
        .replay (replay)
    );

    a_r4_out_needs_take: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (in_cnt != '0));

    a_r5_done_after_last: assert property (@(posedge clk) disable iff (rst)
        last |=> done);

endmodule

// File: tb/sim_fft_bfly_guard.sv
module sim_fft_bfly_guard;

    localparam int NP = 4;

    typedef struct {
        logic [31:0] x;
        logic [31:0] y;
        int          due;
        bit          last;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2ns clk = ~clk;

    logic        st [2];
    logic        iv [2];
    logic        rdy[2];
    logic        ov [2];
    logic        dn [2];
    logic        er [2];
    logic        rp [2];
    logic [31:0] fp [2];
    logic [31:0] pa [2];
    logic [31:0] pb [2];
    logic [31:0] pw [2];
    logic [31:0] ox [2];
    logic [31:0] oy [2];

    int   tot = 0;
    int   bad = 0;
    int   cyc = 0;
    exp_t q0[$];
    exp_t q1[$];
    int   lastc [2];
    bit   experr[2];

    fft_bfly_guard #(.LOG2N(3), .HALF_RATE(1'b0)) u0 (
        .clk(clk), .rst(rst), .start(st[0]), .first_pt(fp[0]),
        .in_valid(iv[0]), .in_ready(rdy[0]), .a_pt(pa[0]), .b_pt(pb[0]),
        .tw_pt(pw[0]), .out_valid(ov[0]), .x_pt(ox[0]), .y_pt(oy[0]),
        .done(dn[0]), .error(er[0]), .replay(rp[0]));

    fft_bfly_guard #(.LOG2N(3), .HALF_RATE(1'b1)) u1 (
        .clk(clk), .rst(rst), .start(st[1]), .first_pt(fp[1]),
        .in_valid(iv[1]), .in_ready(rdy[1]), .a_pt(pa[1]), .b_pt(pb[1]),
        .tw_pt(pw[1]), .out_valid(ov[1]), .x_pt(ox[1]), .y_pt(oy[1]),
        .done(dn[1]), .error(er[1]), .replay(rp[1]));

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        tot++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    function automatic longint rnd15(input longint v);
        return (v + 16384) >>> 15;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            for (int d = 0; d < 2; d++) begin
                exp_t e;
                bit   have;
                have = 1'b0;
                if (ov[d]) begin
                    if (d == 0 && q0.size() > 0) begin e = q0.pop_front(); have = 1'b1; end
                    if (d == 1 && q1.size() > 0) begin e = q1.pop_front(); have = 1'b1; end
                    chk(have, "R4 unexpected output", 1, 0);
                    if (have) begin
                        chk(ox[d] == e.x, "R1 x value", longint'(ox[d]), longint'(e.x));
                        chk(oy[d] == e.y, "R1 y value", longint'(oy[d]), longint'(e.y));
                        chk(cyc == e.due, d == 0 ? "R2 output cycle" : "R3 output cycle",
                            cyc, e.due);
                        if (e.last) lastc[d] = cyc;
                    end
                end else begin
                    if (d == 0 && q0.size() > 0 && q0[0].due < cyc) begin
                        chk(1'b0, "R2 missing output", 0, q0[0].due);
                        void'(q0.pop_front());
                    end
                    if (d == 1 && q1.size() > 0 && q1[0].due < cyc) begin
                        chk(1'b0, "R3 missing output", 0, q1[0].due);
                        void'(q1.pop_front());
                    end
                end
                if (dn[d]) begin
                    chk(cyc == lastc[d] + 1, "R5 done timing", cyc, lastc[d] + 1);
                    chk(er[d] == experr[d], "R6 R7 check result", er[d], experr[d]);
                    chk(rp[d] == experr[d], "R8 replay rise", rp[d], experr[d]);
                end else begin
                    chk(er[d] == 1'b0, "R7 error without done", er[d], 0);
                end
            end
        end
    end

    task automatic run_xf(input int d, input int k, input int rre, input int rim,
                          input int ore[NP], input int oim[NP]);
        logic [31:0] av[NP];
        logic [31:0] bv[NP];
        logic [31:0] wv[NP];
        exp_t        ev[NP];
        longint      sre;
        longint      sim;
        longint      dr;
        longint      di;
        int          lat;
        int          w8;
        sre = 0;
        sim = 0;
        lat = (d == 0) ? 1 : 2;
        for (int i = 0; i < NP; i++) begin
            logic signed [15:0] ar, ai, br, bi, wr, wi, xr, xi, yr, yi;
            longint pr, pi;
            ar = 16'(rre + ore[i]);
            ai = 16'(rim + oim[i]);
            br = 16'(300 * (i + 1) - 500 + 37 * k);
            bi = 16'(-700 + 410 * i - 13 * k);
            wr = 16'((i % 2 == 1) ? 23170 : (-30000 + 1000 * k));
            wi = 16'(12000 - 9000 * i);
            pr = rnd15(longint'(br) * wr - longint'(bi) * wi);
            pi = rnd15(longint'(br) * wi + longint'(bi) * wr);
            xr = 16'(longint'(ar) + pr);
            xi = 16'(longint'(ai) + pi);
            yr = 16'(longint'(ar) - pr);
            yi = 16'(longint'(ai) - pi);
            av[i] = {ar, ai};
            bv[i] = {br, bi};
            wv[i] = {wr, wi};
            ev[i].x = {xr, xi};
            ev[i].y = {yr, yi};
            ev[i].last = (i == NP - 1);
            sre += longint'(xr) + longint'(yr);
            sim += longint'(xi) + longint'(yi);
        end
        dr = (sre >>> 3) - rre;
        di = (sim >>> 3) - rim;
        experr[d] = (dr > 8) || (dr < -8) || (di > 8) || (di < -8);

        @(negedge clk);
        st[d] = 1'b1;
        fp[d] = {16'(rre), 16'(rim)};
        @(negedge clk);
        st[d] = 1'b0;
        chk(rp[d] == 1'b0, "R8 replay cleared by start", rp[d], 0);
        for (int i = 0; i < NP; i++) begin
            iv[d] = 1'b1;
            pa[d] = av[i];
            pb[d] = bv[i];
            pw[d] = wv[i];
            w8 = 0;
            while (!rdy[d] && w8 < 8) begin
                @(negedge clk);
                w8++;
            end
            chk(rdy[d] == 1'b1, "R4 ready during pass", rdy[d], 1);
            ev[i].due = cyc + lat;
            if (d == 0) q0.push_back(ev[i]); else q1.push_back(ev[i]);
            @(negedge clk);
            if (d == 1 && i < NP - 1)
                chk(rdy[d] == 1'b0, "R3 ready gap", rdy[d], 0);
        end
        // keep presenting data after the pass is full: must be ignored
        chk(rdy[d] == 1'b0, "R4 no fifth pair", rdy[d], 0);
        @(negedge clk);
        chk(rdy[d] == 1'b0, "R4 no fifth pair", rdy[d], 0);
        iv[d] = 1'b0;
        w8 = 0;
        while (!dn[d] && w8 < 12) begin
            @(negedge clk);
            w8++;
        end
        chk(dn[d] == 1'b1, "R5 done seen", dn[d], 1);
        repeat (4) begin
            @(negedge clk);
            chk(rp[d] == experr[d], "R8 replay held", rp[d], experr[d]);
            chk(dn[d] == 1'b0, "R5 single pulse", dn[d], 0);
        end
    endtask

    initial begin
        for (int d = 0; d < 2; d++) begin
            st[d] = 1'b0; iv[d] = 1'b0; fp[d] = '0;
            pa[d] = '0; pb[d] = '0; pw[d] = '0;
            lastc[d] = -10; experr[d] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            chk(ov[d] == 0, "R9 out_valid reset", ov[d], 0);
            chk(dn[d] == 0, "R9 done reset", dn[d], 0);
            chk(er[d] == 0, "R9 error reset", er[d], 0);
            chk(rp[d] == 0, "R9 replay reset", rp[d], 0);
            chk(rdy[d] == 0, "R9 in_ready reset", rdy[d], 0);
        end
        for (int d = 0; d < 2; d++) begin
            // R4: traffic before any start is ignored
            iv[d] = 1'b1;
            pa[d] = 32'h0010_0020; pb[d] = 32'h0100_0200; pw[d] = 32'h4000_0000;
            repeat (3) begin
                @(negedge clk);
                chk(rdy[d] == 0, "R4 idle ignored", rdy[d], 0);
                chk(ov[d] == 0, "R4 idle no output", ov[d], 0);
            end
            iv[d] = 1'b0;
            run_xf(d, 0,   100,  -50, '{0, 0, 0, 0},     '{0, 0, 0, 0});       // R6 pass
            run_xf(d, 1, -1200,  700, '{5, -5, 20, -20}, '{-3, 3, 7, -7});     // R6 pass
            run_xf(d, 2,   300,  300, '{8, 8, 8, 8},     '{0, 0, 0, 0});       // R6 edge +8
            run_xf(d, 3,   300,  300, '{8, 8, 8, 12},    '{0, 0, 0, 0});       // R7 +9 fail
            run_xf(d, 4,   -40,  900, '{0, 0, 0, 0},     '{-8, -8, -8, -12});  // R7 -9 fail im
            run_xf(d, 5,   -40,  900, '{0, 0, 0, 0},     '{-8, -8, -8, -8});   // R6 edge -8
            // R4: traffic after a finished pass is ignored
            iv[d] = 1'b1;
            repeat (3) begin
                @(negedge clk);
                chk(rdy[d] == 0, "R4 after pass ignored", rdy[d], 0);
                chk(ov[d] == 0, "R4 after pass no output", ov[d], 0);
            end
            iv[d] = 1'b0;
        end
        repeat (4) @(negedge clk);
        chk(q0.size() == 0 && q1.size() == 0, "R1 all outputs seen",
            q0.size() + q1.size(), 0);
        $display("test done: total=%0d bad=%0d", tot, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tot++;
        bad++;
        $display("FAIL watchdog expired act=%0d exp=0", cyc);
        $display("test done: total=%0d bad=%0d", tot, bad);
        $finish;
    end

endmodule